// File: doc/BRIEF.md
# I2C Register-Access Target

This block lets an external I2C controller read and write a bank of 256 byte-wide registers. It watches the bus through sampled SCL and SDA inputs and pulls SDA low through an open-drain enable. Every access opens with a start condition and an address byte. That byte holds a 7-bit target address and a direction bit. In a write, the first data byte sets the register pointer and any later bytes are stored. In a read, bytes are sent from the current read pointer.

The pointer is kept from one transaction to the next. A read that is not preceded by an offset continues one past the last byte read. If a write has set the offset since that read, it starts at that offset instead. Both SCL and SDA are sampled on the system clock, so that clock must run many times faster than SCL. Clock stretching, general call, 10-bit addressing and arbitration are not handled.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, SDA is released (`sda_pull`=0) and the read pointer is 00h. Register i holds i XOR 5Ah, so a read after reset returns 5Ah, 5Bh, 58h, and so on.
- R2: An address byte is sent MSB first: 7 address bits, then the direction bit (0 = write, 1 = read). On a match the target pulls SDA low in the ninth clock. On a mismatch it pulls SDA in no bit, and all bytes up to the next start or stop leave the registers and the pointer unchanged.
- R3: In a write, the byte after the address sets the offset. Every later byte is stored at the offset, the offset plus one, and so on. The target acknowledges each of these bytes.
- R4: A write that carries only an offset byte and then a stop stores nothing. It only sets where the next read starts.
- R5: An offset write, then a repeated start and a read address, returns bytes MSB first starting at that offset.
- R6: A read with no offset before it continues at the byte after the last byte read. After reset it starts at 00h.
- R7: If a write has set the offset since the last read, a plain read starts at that offset, even when data bytes followed the offset in the write.
- R8: When the controller answers a read byte with NACK, the target releases SDA and drives no further bit until the next start or stop.
- R9: The read pointer moves forward after every byte sent, whether the controller acknowledged it or not.
- R10: Both the read pointer and the write pointer wrap from FFh to 00h.
- R11: A start condition in the middle of a byte drops that byte and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run well above the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_addr | input | 7 | Address this target answers to |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |

## Verification
Two things happen in the same cycle when the last data byte of a write is stored: the register is written and the write pointer moves forward. At offset FFh that same cycle also wraps the pointer to 00h. The bench provokes this by writing three bytes starting at FEh. It judges the result with a repeated-start read from FEh, which must return the three bytes in order, and with a plain read that must then continue at 01h. A second collision is a NACK on a read byte together with the pointer advance. The bench checks it by clocking further bits, which must read high, and by confirming that the next plain read starts one byte later.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = BYTE_W;
  localparam int DEPTH  = 1 << PTR_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_OFFS,
    PH_DATA
  } rx_phase_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_in};
      sda_p <= {sda_p[STAGES-2:0], sda_in};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_regbank.sv
module i2c_tgt_regbank
  import i2c_tgt_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RST_XOR = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= BYTE_W'(i) ^ RST_XOR;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] RST_XOR     = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] tgt_addr,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  tgt_state_e        state_q, state_d;
  rx_phase_e         phase_q, phase_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic              is_read_q, is_read_d, nack_q, nack_d, oe_q, oe_d;
  logic              mem_we, rd_adv;
  logic [BYTE_W-1:0] rd_data;

  i2c_tgt_regbank #(.RST_XOR(RST_XOR)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .we(mem_we), .waddr(wr_ptr_q),
    .wdata(sh_q), .raddr(rd_ptr_q), .rdata(rd_data)
  );

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    rd_ptr_d  = rd_ptr_q;
    wr_ptr_d  = wr_ptr_q;
    is_read_d = is_read_q;
    nack_d    = nack_q;
    oe_d      = oe_q;
    mem_we    = 1'b0;
    rd_adv    = 1'b0;
    if (bus_stop) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (bus_start) begin
      state_d = ST_RX;
      phase_d = PH_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            state_d = ST_ACK;
            oe_d    = 1'b1;
            case (phase_q)
              PH_ADDR: begin
                if (sh_q[7:1] == tgt_addr) begin
                  is_read_d = sh_q[0];
                end else begin
                  state_d = ST_IDLE;
                  oe_d    = 1'b0;
                end
              end
              PH_OFFS: begin
                rd_ptr_d = sh_q;
                wr_ptr_d = sh_q;
                phase_d  = PH_DATA;
              end
              default: begin
                mem_we   = 1'b1;
                wr_ptr_d = wr_ptr_q + 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (is_read_q && phase_q == PH_ADDR) begin
              state_d = ST_TX;
              sh_d    = rd_data;
              oe_d    = ~rd_data[7];
            end else begin
              state_d = ST_RX;
              oe_d    = 1'b0;
              if (phase_q == PH_ADDR) phase_d = PH_OFFS;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              state_d  = ST_RACK;
              oe_d     = 1'b0;
              rd_adv   = 1'b1;
              rd_ptr_d = rd_ptr_q + 1'b1;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              cnt_d = cnt_q + 4'd1;
              oe_d  = ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) nack_d = sda_s;
          if (scl_fall) begin
            if (nack_q) begin
              state_d = ST_IDLE;
            end else begin
              state_d = ST_TX;
              sh_d    = rd_data;
              cnt_d   = '0;
              oe_d    = ~rd_data[7];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      cnt_q     <= '0;
      sh_q      <= '0;
      rd_ptr_q  <= '0;
      wr_ptr_q  <= '0;
      is_read_q <= 1'b0;
      nack_q    <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      phase_q   <= phase_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      rd_ptr_q  <= rd_ptr_d;
      wr_ptr_q  <= wr_ptr_d;
      is_read_q <= is_read_d;
      nack_q    <= nack_d;
      oe_q      <= oe_d;
    end
  end

  assign sda_pull = oe_q;

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_pull);

  // R2
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RX && phase_q == PH_ADDR && scl_fall && cnt_q == 4'd8 &&
     !bus_start && !bus_stop && sh_q[7:1] != tgt_addr) |=> !sda_pull);

  // R3
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (wr_ptr_q == PTR_W'($past(wr_ptr_q) + 1'b1)));

  // R8
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RACK && scl_fall && nack_q && !bus_start && !bus_stop)
    |=> (state_q == ST_IDLE && !sda_pull));

  // R10
  rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv && rd_ptr_q == '1) |=> (rd_ptr_q == '0));
endmodule

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;
  localparam int         Q   = 10;
  localparam logic [6:0] DEV = 7'h2C;
  localparam logic [6:0] BAD = 7'h2D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_line;
  assign sda_line = sda_m & ~sda_pull;

  always #2 clk = ~clk;

  i2c_reg_target u0 (
    .clk(clk), .rst_n(rst_n), .tgt_addr(DEV),
    .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [7:0] bmem [256];
  logic [7:0] rptr, wptr;
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compare each byte read off the bus with the model
  initial forever begin
    @(negedge clk);
    if (act_q.size() != 0 && exp_q.size() != 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(a == e, t, a, e);
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    r = sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r);
    bit_x(1'b1, r);
    acked = !r;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, r);
      b[i] = r;
    end
    bit_x(!give_ack, r);
  endtask

  // driver: read n bytes, push the expected ones into the scoreboard
  task automatic read_bytes(input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(bmem[rptr]);
      tag_q.push_back(req);
      rptr = rptr + 8'd1;
      recv_byte(i != n - 1, b);
      act_q.push_back(b);
    end
  endtask

  task automatic plain_read(input int n, input string req);
    bit ak;
    bus_start();
    send_byte({DEV, 1'b1}, ak);
    chk(ak, "R2 read address ack", {7'd0, ak}, 8'd1);
    read_bytes(n, req);
    bus_stop();
  endtask

  task automatic write_txn(input logic [7:0] off, input int n, input logic [7:0] d [4], input string req);
    bit ak;
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    chk(ak, "R2 write address ack", {7'd0, ak}, 8'd1);
    send_byte(off, ak);
    chk(ak, "R3 offset ack", {7'd0, ak}, 8'd1);
    rptr = off;
    wptr = off;
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ak);
      chk(ak, req, {7'd0, ak}, 8'd1);
      bmem[wptr] = d[i];
      wptr = wptr + 8'd1;
    end
    bus_stop();
  endtask

  task automatic rs_read(input logic [7:0] off, input int n, input string req);
    bit ak;
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(off, ak);
    chk(ak, "R5 offset ack", {7'd0, ak}, 8'd1);
    rptr = off;
    wptr = off;
    bus_rstart();
    send_byte({DEV, 1'b1}, ak);
    chk(ak, "R5 read address ack", {7'd0, ak}, 8'd1);
    read_bytes(n, req);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [4];
    logic [7:0] b;
    logic r;
    bit ak;
    for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'h5A;
    rptr = 8'h00;
    wptr = 8'h00;
    repeat (5) @(negedge clk);
    chk(sda_pull == 1'b0, "R1 released in reset", {7'd0, sda_pull}, 8'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(sda_pull == 1'b0, "R1 released after reset", {7'd0, sda_pull}, 8'd0);

    // R1 R6: plain read from power-up, then continue
    plain_read(3, "R1 power-up read from 00h");
    plain_read(2, "R6 plain read continues");

    // R3 R5: write data then repeated-start read back
    d = '{8'h11, 8'h22, 8'h33, 8'h00};
    write_txn(8'h10, 3, d, "R3 data byte ack");
    rs_read(8'h10, 3, "R5 repeated start read");

    // R4: offset-only write
    d = '{8'h00, 8'h00, 8'h00, 8'h00};
    write_txn(8'h20, 0, d, "R4 none");
    plain_read(2, "R4 offset-only sets start");

    // R7: plain read after write with data starts at written offset
    d = '{8'hAA, 8'hBB, 8'h00, 8'h00};
    write_txn(8'h40, 2, d, "R3 data byte ack");
    plain_read(2, "R7 read from write offset");

    // R2: wrong address write is ignored
    bus_start();
    send_byte({BAD, 1'b0}, ak);
    chk(!ak, "R2 mismatch no ack", {7'd0, ak}, 8'd0);
    send_byte(8'h30, ak);
    chk(!ak, "R2 mismatch offset ignored", {7'd0, ak}, 8'd0);
    send_byte(8'h77, ak);
    chk(!ak, "R2 mismatch data ignored", {7'd0, ak}, 8'd0);
    bus_stop();
    plain_read(1, "R2 pointer kept after mismatch");
    // R2: wrong address read leaves line high
    bus_start();
    send_byte({BAD, 1'b1}, ak);
    chk(!ak, "R2 mismatch read no ack", {7'd0, ak}, 8'd0);
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R2 mismatch read released", b, 8'hFF);
    bus_stop();

    // R8 R9: NACK then extra clocks
    bus_start();
    send_byte({DEV, 1'b1}, ak);
    read_bytes(1, "R8 byte before nack");
    for (int i = 0; i < 9; i++) begin
      bit_x(1'b1, r);
      chk(r == 1'b1, "R8 released after nack", {7'd0, r}, 8'd1);
    end
    bus_stop();
    plain_read(1, "R9 advanced past nacked byte");

    // R10: write and read across FFh
    d = '{8'h01, 8'h02, 8'h03, 8'h00};
    write_txn(8'hFE, 3, d, "R10 write across wrap ack");
    rs_read(8'hFE, 3, "R10 read across wrap");
    plain_read(1, "R10 pointer continues after wrap");

    // R11: start inside a byte abandons it
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    bit_x(1'b1, r);
    bit_x(1'b0, r);
    bit_x(1'b1, r);
    bus_rstart();
    send_byte({DEV, 1'b1}, ak);
    chk(ak, "R11 new address phase ack", {7'd0, ak}, 8'd1);
    read_bytes(1, "R11 partial offset dropped");
    bus_stop();

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule